// File: doc/BRIEF.md
# Privileged System Instruction Outcome Unit

This unit sits beside the execute stage of a RISC-V core and settles what happens to the system-class instructions: environment call, breakpoint, machine return, supervisor return, wait-for-interrupt, address-translation fence and instruction fence. Each cycle it may be handed one raw 32-bit instruction word. Alongside the word it receives the hart's current privilege level, three trap-control status bits, the values read from the two source registers and the program counter. One cycle later it reports exactly one outcome for that instruction.

The outcome is one of six. The instruction may retire as a plain no-op. It may be rejected as an illegal instruction. It may raise a synchronous trap, with a cause code and a fault value. It may request a return to machine or supervisor mode. It may request a wait for an interrupt. It may request a TLB flush. A flush request carries its two qualifiers, the virtual address and the ASID, and either of them can be a wildcard that covers everything. Vector selection for traps, the CSR file and the TLB are all left to the blocks that consume these outputs.

Top module: `sys_instr_outcome`

## Requirements
- R1: Recognised words are ECALL 0x00000073, EBREAK 0x00100073, SRET 0x10200073, MRET 0x30200073, WFI 0x10500073 and FENCE.I 0x0000100F. SFENCE.VMA is accepted as bits[31:25]=0001001, bits[14:12]=000, bits[11:7]=00000 and bits[6:0]=1110011, with any source fields. Every other word reports illegal.
- R2: FENCE.I reports retire-ok and nothing else, at every privilege level.
- R3: ECALL reports a trap with cause 8 from user (privilege code 00, and the reserved code 10 is handled as user), 9 from supervisor (01) and 11 from machine (11). Its fault value is zero.
- R4: EBREAK reports a trap with cause 3 and a fault value equal to the program counter presented with it.
- R5: MRET reports a return request with the machine flag set when the level is machine. At any other level it reports illegal.
- R6: SRET is illegal from user, and illegal from supervisor when the return-trap bit (tsr) is set. Otherwise it reports a return request with the machine flag clear.
- R7: WFI is always legal from machine and always illegal from user. From supervisor it is illegal when the timeout-wait bit (tw) is set. When legal it reports a wait request.
- R8: SFENCE.VMA is illegal from user, and illegal from supervisor when the VM-trap bit (tvm) is set. Otherwise it reports a flush request.
- R9: On a flush, an rs1 field of 0 sets the all-addresses flag and gives an address qualifier of 0. Any other rs1 field clears the flag and passes rs1_val. The rs2 field and rs2_val drive the all-ASIDs flag and the ASID qualifier in the same way.
- R10: Outcomes appear on the cycle after in_valid. Exactly one outcome bit is high when out_valid is high, and none is high when it is low.
- R11: While reset is held, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Raw instruction word |
| priv | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine |
| tw | input | 1 | Wait-for-interrupt timeout trap bit |
| tvm | input | 1 | Translation-management trap bit |
| tsr | input | 1 | Supervisor-return trap bit |
| rs1_val | input | XLEN | Value of source register 1 |
| rs2_val | input | XLEN | Value of source register 2 |
| pc | input | XLEN | Address of the instruction |
| out_valid | output | 1 | An outcome is reported this cycle |
| res_ok | output | 1 | Retires as a no-op |
| res_illegal | output | 1 | Illegal instruction |
| res_trap | output | 1 | Synchronous trap raised |
| trap_cause | output | 4 | Trap cause code |
| trap_tval | output | XLEN | Trap fault value |
| res_ret | output | 1 | Return request |
| ret_to_m | output | 1 | Return is from machine mode (else supervisor) |
| res_wfi | output | 1 | Wait-for-interrupt request |
| res_flush | output | 1 | TLB flush request |
| flush_all_addr | output | 1 | Flush covers all addresses |
| flush_all_asid | output | 1 | Flush covers all ASIDs |
| flush_vaddr | output | XLEN | Address qualifier |
| flush_asid | output | XLEN | ASID qualifier |

## Verification
The bench builds the unit with XLEN set to 32. Every recognised instruction, plus a set of near-miss words, is crossed with all four privilege codes and all eight combinations of tw, tvm and tsr. SFENCE.VMA is also run with each mix of zero and non-zero source fields. With this sweep, every legality rule and every cause code is exercised at every level, and so are both wildcard paths of the flush qualifiers. Idle cycles between instructions show that nothing is reported when no instruction is presented.

// File: rtl/sys_chk_pkg.sv
package sys_chk_pkg;

  localparam int CAUSE_W = 4;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } priv_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_ECALL,
    OP_EBREAK,
    OP_MRET,
    OP_SRET,
    OP_WFI,
    OP_SFENCE,
    OP_FENCEI
  } sysop_e;

  typedef struct packed {
    logic ok;
    logic illegal;
    logic trap;
    logic ret;
    logic wfi;
    logic flush;
  } outcome_t;

  localparam logic [CAUSE_W-1:0] CAUSE_BRK    = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_ENV_U  = 4'd8;
  localparam logic [CAUSE_W-1:0] CAUSE_ENV_S  = 4'd9;
  localparam logic [CAUSE_W-1:0] CAUSE_ENV_M  = 4'd11;

endpackage

// File: rtl/sys_op_decode.sv
module sys_op_decode
  import sys_chk_pkg::*;
(
  input  logic [31:0] instr,
  output sysop_e      op,
  output logic        rs1_is_zero,
  output logic        rs2_is_zero
);

  logic [6:0]  opc;
  logic [2:0]  fn3;
  logic [4:0]  rd_f;
  logic [4:0]  rs1_f;
  logic [11:0] imm_f;
  logic        sys_base;

  assign opc   = instr[6:0];
  assign rd_f  = instr[11:7];
  assign fn3   = instr[14:12];
  assign rs1_f = instr[19:15];
  assign imm_f = instr[31:20];

  assign sys_base    = (opc == 7'b1110011) && (fn3 == 3'b000) && (rd_f == 5'd0);
  assign rs1_is_zero = (rs1_f == 5'd0);
  assign rs2_is_zero = (instr[24:20] == 5'd0);

  always_comb begin
    op = OP_NONE;
    if (instr == 32'h0000_100F) begin
      op = OP_FENCEI;
    end else if (sys_base && instr[31:25] == 7'b0001001) begin
      op = OP_SFENCE;
    end else if (sys_base && rs1_is_zero) begin
      case (imm_f)
        12'h000: op = OP_ECALL;
        12'h001: op = OP_EBREAK;
        12'h102: op = OP_SRET;
        12'h302: op = OP_MRET;
        12'h105: op = OP_WFI;
        default: op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/sys_outcome.sv
module sys_outcome
  import sys_chk_pkg::*;
(
  input  sysop_e               op,
  input  logic [1:0]           priv,
  input  logic                 tw,
  input  logic                 tvm,
  input  logic                 tsr,
  output outcome_t             res,
  output logic [CAUSE_W-1:0]   cause,
  output logic                 ret_m
);

  logic lvl_m;
  logic lvl_s;

  assign lvl_m = (priv == PRIV_MACH);
  assign lvl_s = (priv == PRIV_SUPER);

  always_comb begin
    res   = '0;
    cause = '0;
    ret_m = 1'b0;
    unique case (op)
      OP_FENCEI: res.ok = 1'b1;
      OP_ECALL: begin
        res.trap = 1'b1;
        cause    = lvl_m ? CAUSE_ENV_M : (lvl_s ? CAUSE_ENV_S : CAUSE_ENV_U);
      end
      OP_EBREAK: begin
        res.trap = 1'b1;
        cause    = CAUSE_BRK;
      end
      OP_MRET: begin
        res.ret     = lvl_m;
        res.illegal = !lvl_m;
        ret_m       = lvl_m;
      end
      OP_SRET: begin
        res.ret     = lvl_m || (lvl_s && !tsr);
        res.illegal = !(lvl_m || (lvl_s && !tsr));
      end
      OP_WFI: begin
        res.wfi     = lvl_m || (lvl_s && !tw);
        res.illegal = !(lvl_m || (lvl_s && !tw));
      end
      OP_SFENCE: begin
        res.flush   = lvl_m || (lvl_s && !tvm);
        res.illegal = !(lvl_m || (lvl_s && !tvm));
      end
      default: res.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/sys_instr_outcome.sv
module sys_instr_outcome
  import sys_chk_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [31:0]        instr,
  input  logic [1:0]         priv,
  input  logic               tw,
  input  logic               tvm,
  input  logic               tsr,
  input  logic [XLEN-1:0]    rs1_val,
  input  logic [XLEN-1:0]    rs2_val,
  input  logic [XLEN-1:0]    pc,
  output logic               out_valid,
  output logic               res_ok,
  output logic               res_illegal,
  output logic               res_trap,
  output logic [3:0]         trap_cause,
  output logic [XLEN-1:0]    trap_tval,
  output logic               res_ret,
  output logic               ret_to_m,
  output logic               res_wfi,
  output logic               res_flush,
  output logic               flush_all_addr,
  output logic               flush_all_asid,
  output logic [XLEN-1:0]    flush_vaddr,
  output logic [XLEN-1:0]    flush_asid
);

  sysop_e              dec_op;
  logic                dec_rs1_z;
  logic                dec_rs2_z;
  outcome_t            comb_res;
  logic [CAUSE_W-1:0]  comb_cause;
  logic                comb_ret_m;

  sys_op_decode u_dec (
    .instr       (instr),
    .op          (dec_op),
    .rs1_is_zero (dec_rs1_z),
    .rs2_is_zero (dec_rs2_z)
  );

  sys_outcome u_rules (
    .op    (dec_op),
    .priv  (priv),
    .tw    (tw),
    .tvm   (tvm),
    .tsr   (tsr),
    .res   (comb_res),
    .cause (comb_cause),
    .ret_m (comb_ret_m)
  );

  // next-state values
  outcome_t            res_d, res_q;
  logic                vld_d, vld_q;
  logic [CAUSE_W-1:0]  cause_d, cause_q;
  logic [XLEN-1:0]     tval_d, tval_q;
  logic                retm_d, retm_q;
  logic                aall_d, aall_q, sall_d, sall_q;
  logic [XLEN-1:0]     va_d, va_q, as_d, as_q;
  logic                data_en;

  assign data_en = in_valid;

  always_comb begin
    vld_d   = in_valid;
    res_d   = in_valid ? comb_res : '0;
    cause_d = comb_res.trap ? comb_cause : '0;
    tval_d  = (dec_op == OP_EBREAK) ? pc : '0;
    retm_d  = comb_ret_m;
    aall_d  = comb_res.flush && dec_rs1_z;
    sall_d  = comb_res.flush && dec_rs2_z;
    va_d    = (comb_res.flush && !dec_rs1_z) ? rs1_val : '0;
    as_d    = (comb_res.flush && !dec_rs2_z) ? rs2_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      retm_q  <= 1'b0;
      aall_q  <= 1'b0;
      sall_q  <= 1'b0;
      va_q    <= '0;
      as_q    <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
      if (data_en) begin
        cause_q <= cause_d;
        tval_q  <= tval_d;
        retm_q  <= retm_d;
        aall_q  <= aall_d;
        sall_q  <= sall_d;
        va_q    <= va_d;
        as_q    <= as_d;
      end
    end
  end

  assign out_valid      = vld_q;
  assign res_ok         = res_q.ok;
  assign res_illegal    = res_q.illegal;
  assign res_trap       = res_q.trap;
  assign res_ret        = res_q.ret;
  assign res_wfi        = res_q.wfi;
  assign res_flush      = res_q.flush;
  assign trap_cause     = cause_q;
  assign trap_tval      = tval_q;
  assign ret_to_m       = retm_q;
  assign flush_all_addr = aall_q;
  assign flush_all_asid = sall_q;
  assign flush_vaddr    = va_q;
  assign flush_asid     = as_q;

  // R10: one outcome per reported instruction, none when idle
  p_one_outcome_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones({res_ok, res_illegal, res_trap, res_ret, res_wfi, res_flush}) == 1);
  p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> {res_ok, res_illegal, res_trap, res_ret, res_wfi, res_flush} == 6'b0);
  // R7: user-level WFI is rejected
  p_wfi_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_op == OP_WFI && priv[0] == 1'b0) |=> res_illegal);
  // R8: supervisor fence under tvm is rejected
  p_sfence_tvm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_op == OP_SFENCE && priv == PRIV_SUPER && tvm) |=> res_illegal);
  // R5: machine return only from machine level
  p_mret_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_op == OP_MRET && priv != PRIV_MACH) |=> res_illegal);
  // R4: breakpoint cause
  p_ebreak_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_op == OP_EBREAK) |=> (res_trap && trap_cause == 4'd3));
  // R9: a wildcard address carries a zero qualifier
  p_wild_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_flush && flush_all_addr) |-> flush_vaddr == '0);

endmodule

// File: tb/sys_instr_outcome_bench.sv
module sys_instr_outcome_bench;

  localparam int XLEN = 32;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic [31:0]     instr;
  logic [1:0]      priv;
  logic            tw, tvm, tsr;
  logic [XLEN-1:0] rs1_val, rs2_val, pc;
  logic            out_valid, res_ok, res_illegal, res_trap, res_ret, ret_to_m;
  logic            res_wfi, res_flush, flush_all_addr, flush_all_asid;
  logic [3:0]      trap_cause;
  logic [XLEN-1:0] trap_tval, flush_vaddr, flush_asid;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  sys_instr_outcome #(.XLEN(XLEN)) u_sys_instr_outcome (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .priv(priv),
    .tw(tw), .tvm(tvm), .tsr(tsr), .rs1_val(rs1_val), .rs2_val(rs2_val), .pc(pc),
    .out_valid(out_valid), .res_ok(res_ok), .res_illegal(res_illegal),
    .res_trap(res_trap), .trap_cause(trap_cause), .trap_tval(trap_tval),
    .res_ret(res_ret), .ret_to_m(ret_to_m), .res_wfi(res_wfi), .res_flush(res_flush),
    .flush_all_addr(flush_all_addr), .flush_all_asid(flush_all_asid),
    .flush_vaddr(flush_vaddr), .flush_asid(flush_asid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side instruction list: 0 ecall,1 ebreak,2 mret,3 sret,4 wfi,5 sfence,6 fence.i, 7.. near misses
  function automatic logic [31:0] word_of(input int k, input logic [4:0] r1, input logic [4:0] r2);
    case (k)
      0: return 32'h0000_0073;
      1: return 32'h0010_0073;
      2: return 32'h3020_0073;
      3: return 32'h1020_0073;
      4: return 32'h1050_0073;
      5: return {7'b0001001, r2, r1, 3'b000, 5'b00000, 7'b1110011};
      6: return 32'h0000_100F;
      7: return {7'b0001001, r2, r1, 3'b000, 5'b00001, 7'b1110011};
      8: return 32'h0000_108F;
      9: return 32'h0020_0073;
      10: return 32'h3020_8073;
      11: return 32'h0000_0000;
      default: return 32'h1050_1073;
    endcase
  endfunction

  // expected kind: 0 ok,1 illegal,2 trap,3 ret,4 wfi,5 flush
  function automatic int kind_of(input int k, input logic [1:0] p, input logic w, input logic v, input logic s);
    bit m = (p == 2'b11);
    bit sv = (p == 2'b01);
    case (k)
      0, 1: return 2;
      2: return m ? 3 : 1;
      3: return (m || (sv && !s)) ? 3 : 1;
      4: return (m || (sv && !w)) ? 4 : 1;
      5: return (m || (sv && !v)) ? 5 : 1;
      6: return 0;
      default: return 1;
    endcase
  endfunction

  task automatic run_one(input int k, input logic [1:0] p, input logic w, input logic v,
                         input logic s, input logic [4:0] r1, input logic [4:0] r2);
    int kd;
    logic [5:0] exp_vec;
    logic [5:0] act_vec;
    logic [3:0] ecause;
    @(negedge clk);
    in_valid = 1'b1;
    instr    = word_of(k, r1, r2);
    priv = p; tw = w; tvm = v; tsr = s;
    rs1_val  = 32'hA5C3_1000 + {27'd0, r1};
    rs2_val  = 32'h0000_0040 + {27'd0, r2};
    pc       = 32'h8000_0000 + 32'(k * 4);
    @(negedge clk);
    in_valid = 1'b0;
    kd = kind_of(k, p, w, v, s);
    exp_vec = 6'b100000 >> kd;
    act_vec = {res_ok, res_illegal, res_trap, res_ret, res_wfi, res_flush};
    chk(out_valid == 1'b1, "R10 out_valid", 64'(out_valid), 64'd1);
    chk(act_vec == exp_vec, (k >= 7) ? "R1 outcome" : (k == 6) ? "R2 outcome" :
        (k <= 1) ? "R3/R4 outcome" : (k == 2) ? "R5 outcome" : (k == 3) ? "R6 outcome" :
        (k == 4) ? "R7 outcome" : "R8 outcome", 64'(act_vec), 64'(exp_vec));
    if (k == 0) begin
      ecause = (p == 2'b11) ? 4'd11 : (p == 2'b01) ? 4'd9 : 4'd8;
      chk(trap_cause == ecause, "R3 cause", 64'(trap_cause), 64'(ecause));
      chk(trap_tval == '0, "R3 tval", 64'(trap_tval), 64'd0);
    end
    if (k == 1) begin
      chk(trap_cause == 4'd3, "R4 cause", 64'(trap_cause), 64'd3);
      chk(trap_tval == pc, "R4 tval", 64'(trap_tval), 64'(pc));
    end
    if (kd == 3)
      chk(ret_to_m == (k == 2), "R5 ret_to_m", 64'(ret_to_m), 64'(k == 2));
    if (kd == 5) begin
      chk(flush_all_addr == (r1 == 5'd0), "R9 all_addr", 64'(flush_all_addr), 64'(r1 == 5'd0));
      chk(flush_all_asid == (r2 == 5'd0), "R9 all_asid", 64'(flush_all_asid), 64'(r2 == 5'd0));
      chk(flush_vaddr == ((r1 == 5'd0) ? 32'd0 : rs1_val), "R9 vaddr", 64'(flush_vaddr),
          64'((r1 == 5'd0) ? 32'd0 : rs1_val));
      chk(flush_asid == ((r2 == 5'd0) ? 32'd0 : rs2_val), "R9 asid", 64'(flush_asid),
          64'((r2 == 5'd0) ? 32'd0 : rs2_val));
    end
    // idle cycle: nothing reported (R10)
    @(negedge clk);
    chk(out_valid == 1'b0 && {res_ok, res_illegal, res_trap, res_ret, res_wfi, res_flush} == 6'b0,
        "R10 idle", 64'({out_valid, res_ok, res_illegal, res_trap, res_ret, res_wfi, res_flush}), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; priv = '0;
    tw = 1'b0; tvm = 1'b0; tsr = 1'b0; rs1_val = '0; rs2_val = '0; pc = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({out_valid, res_ok, res_illegal, res_trap, res_ret, res_wfi, res_flush, ret_to_m,
         flush_all_addr, flush_all_asid} == '0 && trap_cause == '0 && trap_tval == '0 &&
        flush_vaddr == '0 && flush_asid == '0, "R11 reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k <= 12; k++) begin
      for (int p = 0; p < 4; p++) begin
        for (int c = 0; c < 8; c++) begin
          if (k == 5 || k == 7) begin
            for (int z = 0; z < 4; z++) begin
              run_one(k, 2'(p), c[0], c[1], c[2], z[0] ? 5'd5 : 5'd0, z[1] ? 5'd7 : 5'd0);
            end
          end else begin
            run_one(k, 2'(p), c[0], c[1], c[2], 5'd0, 5'd0);
          end
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule